// File: doc/BRIEF.md
# EEPROM Write Protection Unit

This unit keeps the status byte of a serial EEPROM and rules on every write that the command logic wants to commit. It holds the write-enable latch, a protect-enable bit that arms the hardware write-protect pin, and a two-bit block selector. The block selector picks how much of the top of the array is locked. The busy flag comes from the internal write timer and is only reflected in the status byte. The command decoder sends one-cycle events: latch set, latch clear, array-write commit and status-write commit. The unit answers each commit one cycle later.

An array commit carries a start address and a byte-enable mask over `LANES` consecutive bytes. The lane addresses wrap inside the current page. The unit returns one permit flag per lane. A status commit carries the new byte. The unit accepts or refuses it according to the latch, the protect-enable bit and the pin level sampled in the commit cycle. Non-volatile contents are modelled by parameterised reset values.

Top module: `eeprom_wprot_unit`

## Requirements
- R1: `sts_o` is laid out as follows: bit 7 is the protect-enable bit, bits 6:4 read 0, bits 3:2 are the block selector, bit 1 is the write-enable latch, and bit 0 follows `busy_i` in the same cycle. A status write changes only bits 7, 3 and 2.
- R2: In the cycle after a clocked reset with `rst_n` low, the latch is 0, and the protect-enable bit and block selector hold `RST_PE` and `RST_BLK`. All registered outputs are 0.
- R3: `wel_set_i` sets the latch and `wel_clr_i` clears it, whatever the protection state. When both arrive in the same cycle, the clear wins.
- R4: While the latch is 0, every array permit is 0 and a status commit is refused, leaving the status byte unchanged.
- R5: The block selector locks the following ranges. 00 locks nothing. 01 locks the top quarter, 0x6000 and above. 10 locks the top half, 0x4000 and above. 11 locks every address. A locked lane is never permitted.
- R6: Lane i addresses the byte at page offset (start offset + i) mod 2^PAGE_W, within the start address's page. Its permit is set only if its `arr_be_i` bit is 1, the commit is accepted and the lane is not locked. `arr_done_o` and `arr_permit_o` appear one cycle after `arr_req_i`.
- R7: With the latch at 1 and the protect-enable bit at 0, a status commit is accepted at either pin level. The new bits appear in `sts_o` one cycle later, together with `sts_ok_o`.
- R8: With the latch at 1 and the protect-enable bit at 1, a status commit is accepted only if `wp_pin_i` is high. Unlocked array bytes stay writable at either pin level.
- R9: An accepted array commit or an accepted status commit clears the latch. A refused status commit leaves the latch as it was.
- R10: While `busy_i` is 1, array commits get no permits and status commits are refused. Neither kind of commit changes any state.
- R11: The pin level is taken only in the status-commit cycle. A later pin change does not alter that commit's result or the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set_i | input | 1 | Latch set event |
| wel_clr_i | input | 1 | Latch clear event |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_pin_i | input | 1 | Write-protect pin level (high = writes allowed) |
| arr_req_i | input | 1 | Array write commit |
| arr_addr_i | input | ADDR_W | Start address of the array write |
| arr_be_i | input | LANES | Byte enables, lane i = start + i within the page |
| sts_req_i | input | 1 | Status write commit |
| sts_wdata_i | input | 8 | New status byte |
| sts_o | output | 8 | Status byte |
| arr_done_o | output | 1 | Array verdict valid |
| arr_permit_o | output | LANES | Per-lane write permits |
| sts_done_o | output | 1 | Status verdict valid |
| sts_ok_o | output | 1 | Status write accepted |

## Verification
The assertions assume that the command decoder never raises `arr_req_i` and `sts_req_i` in the same cycle. They also assume every event input is a single-cycle pulse. The bench drives one commit per step and drops all pulses after each clock, so it stays inside these assumptions. The pin and busy levels are held steady across each step and change only between steps. This is what allows the late pin change in the R11 scenario to be told apart from the level sampled at the commit.

// File: rtl/wprot_pkg.sv
// Package: shared types for the write protection unit.
// Assumes: block selector encoding is fixed by the status byte layout.
package wprot_pkg;
    typedef enum logic [1:0] {
        BLK_NONE    = 2'b00,
        BLK_QUARTER = 2'b01,
        BLK_HALF    = 2'b10,
        BLK_ALL     = 2'b11
    } blk_sel_e;

    localparam int STS_PE_BIT   = 7;
    localparam int STS_BLK_HI   = 3;
    localparam int STS_BLK_LO   = 2;
endpackage

// File: rtl/wprot_lane_map.sv
// Module: expands a start address into LANES byte addresses that wrap
// inside the page of the start address.
// Assumes: page size is a power of two, 2**PAGE_W bytes.
module wprot_lane_map #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0]       base_i,
    output logic [LANES*ADDR_W-1:0] lane_addr_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [HI_W-1:0] page_hi;
    assign page_hi = base_i[ADDR_W-1:PAGE_W];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PAGE_W-1:0] offs;
        // Page offset of lane i, wrapping at the page end.
        assign offs = base_i[PAGE_W-1:0] + PAGE_W'(i);
        assign lane_addr_o[i*ADDR_W +: ADDR_W] = {page_hi, offs};
    end
endmodule

// File: rtl/wprot_range_chk.sv
// Module: decides whether one address lies in the locked upper range
// chosen by the block selector.
// Assumes: ADDR_W >= 2 so the quarter boundary is representable.
module wprot_range_chk
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  blk_sel_e          sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam logic [ADDR_W-1:0] QUARTER_LO = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_LO    = ADDR_W'(1) << (ADDR_W - 1);

    logic [ADDR_W-1:0] lower_bound;

    // Lower edge of the locked region for the current selector.
    always_comb begin
        unique case (sel_i)
            BLK_QUARTER: lower_bound = QUARTER_LO;
            BLK_HALF:    lower_bound = HALF_LO;
            default:     lower_bound = '0;
        endcase
    end

    // An address is locked when a region exists and it is at or above the edge.
    always_comb begin
        locked_o = (sel_i != BLK_NONE) && (addr_i >= lower_bound);
    end
endmodule

// File: rtl/wprot_status_regs.sv
// Module: the latch, protect-enable and block selector registers.
// Assumes: grant inputs are already qualified by the caller; a clear of
// any kind outranks a set in the same cycle.
module wprot_status_regs
    import wprot_pkg::*;
#(
    parameter logic     RST_PE  = 1'b0,
    parameter blk_sel_e RST_BLK = BLK_NONE
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_i,
    input  logic     clr_i,
    input  logic     arr_accept_i,
    input  logic     sts_grant_i,
    input  logic     new_pe_i,
    input  blk_sel_e new_blk_i,
    output logic     wel_o,
    output logic     pe_o,
    output blk_sel_e blk_o
);
    logic wel_drop;
    assign wel_drop = clr_i | arr_accept_i | sts_grant_i;

    // Write-enable latch: clears win over sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (wel_drop) begin
            wel_o <= 1'b0;
        end else if (set_i) begin
            wel_o <= 1'b1;
        end
    end

    // Stored protection bits: loaded only by a granted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_o  <= RST_PE;
            blk_o <= RST_BLK;
        end else if (sts_grant_i) begin
            pe_o  <= new_pe_i;
            blk_o <= new_blk_i;
        end
    end
endmodule

// File: rtl/eeprom_wprot_unit.sv
// Module: top of the write protection unit. Qualifies array and status
// commits against the latch, busy flag, block selector and pin, and
// returns registered verdicts one cycle after each commit.
// Assumes: array and status commits never share a cycle; events are pulses.
module eeprom_wprot_unit
    import wprot_pkg::*;
#(
    parameter int       ADDR_W  = 15,
    parameter int       PAGE_W  = 6,
    parameter int       LANES   = 4,
    parameter logic     RST_PE  = 1'b0,
    parameter logic [1:0] RST_BLK = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              busy_i,
    input  logic              wp_pin_i,
    input  logic              arr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic [LANES-1:0]  arr_be_i,
    input  logic              sts_req_i,
    input  logic [7:0]        sts_wdata_i,
    output logic [7:0]        sts_o,
    output logic              arr_done_o,
    output logic [LANES-1:0]  arr_permit_o,
    output logic              sts_done_o,
    output logic              sts_ok_o
);
    logic                     wel;
    logic                     pe;
    blk_sel_e                 blk;
    logic                     arr_accept;
    logic                     sts_grant;
    logic [LANES*ADDR_W-1:0]  lane_addr;
    logic [LANES-1:0]         lane_locked;
    logic [LANES-1:0]         permit_d;
    logic                     unused_wdata_bits;

    assign unused_wdata_bits = ^{sts_wdata_i[6:4], sts_wdata_i[1:0]};

    // Commit qualification: latch set and no internal cycle running.
    assign arr_accept = arr_req_i & wel & ~busy_i;
    assign sts_grant  = sts_req_i & wel & ~busy_i & (~pe | wp_pin_i);

    wprot_status_regs #(
        .RST_PE  (RST_PE),
        .RST_BLK (blk_sel_e'(RST_BLK))
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (wel_set_i),
        .clr_i        (wel_clr_i),
        .arr_accept_i (arr_accept),
        .sts_grant_i  (sts_grant),
        .new_pe_i     (sts_wdata_i[STS_PE_BIT]),
        .new_blk_i    (blk_sel_e'(sts_wdata_i[STS_BLK_HI:STS_BLK_LO])),
        .wel_o        (wel),
        .pe_o         (pe),
        .blk_o        (blk)
    );

    wprot_lane_map #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .LANES  (LANES)
    ) u_lanes (
        .base_i      (arr_addr_i),
        .lane_addr_o (lane_addr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        wprot_range_chk #(
            .ADDR_W (ADDR_W)
        ) u_rng (
            .sel_i    (blk),
            .addr_i   (lane_addr[i*ADDR_W +: ADDR_W]),
            .locked_o (lane_locked[i])
        );
        // Lane permit: enabled, accepted and outside the locked range.
        assign permit_d[i] = arr_accept & arr_be_i[i] & ~lane_locked[i];
    end

    // Registered verdicts, one cycle after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_done_o   <= 1'b0;
            arr_permit_o <= '0;
            sts_done_o   <= 1'b0;
            sts_ok_o     <= 1'b0;
        end else begin
            arr_done_o   <= arr_req_i;
            arr_permit_o <= permit_d;
            sts_done_o   <= sts_req_i;
            sts_ok_o     <= sts_grant;
        end
    end

    // Status byte assembly; busy passes straight through.
    always_comb begin
        sts_o = {pe, 3'b000, blk, wel, busy_i};
    end
endmodule

// File: rtl/wprot_chk.sv
// Checker: temporal properties of the write protection unit, bound to the top.
// Assumes: commits are single-cycle pulses and never coincide.
module wprot_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wel_clr_i,
    input logic             busy_i,
    input logic             wp_pin_i,
    input logic             arr_req_i,
    input logic             sts_req_i,
    input logic [7:0]       sts_o,
    input logic             arr_done_o,
    input logic [LANES-1:0] arr_permit_o,
    input logic             sts_ok_o
);
    // R1
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o[6:4] == 3'b000);

    // R3
    clr_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_i |=> !sts_o[1]);

    // R4
    no_latch_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req_i && !sts_o[1]) |=> (arr_permit_o == '0));

    // R8
    pin_locks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_req_i && sts_o[7] && !wp_pin_i) |=> !sts_ok_o);

    // R9
    permit_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_done_o && (arr_permit_o != '0)) |-> !sts_o[1]);

    // R10
    busy_refuses_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && sts_req_i) |=> (!sts_ok_o && $stable(sts_o[7:2])));

    // R10
    busy_refuses_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && arr_req_i) |=> (arr_permit_o == '0));

    // R6
    permit_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_done_o |-> (arr_permit_o == '0));
endmodule

bind eeprom_wprot_unit wprot_chk #(.LANES(LANES)) u_wprot_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wel_clr_i    (wel_clr_i),
    .busy_i       (busy_i),
    .wp_pin_i     (wp_pin_i),
    .arr_req_i    (arr_req_i),
    .sts_req_i    (sts_req_i),
    .sts_o        (sts_o),
    .arr_done_o   (arr_done_o),
    .arr_permit_o (arr_permit_o),
    .sts_ok_o     (sts_ok_o)
);

// File: tb/tb_eeprom_wprot_unit.sv
`timescale 1ns/1ps
module tb_eeprom_wprot_unit;
    localparam int ADDR_W = 15;
    localparam int LANES  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_set = 0, s_clr = 0, s_busy = 0, s_wp = 0;
    logic              s_areq = 0, s_sreq = 0;
    logic [ADDR_W-1:0] s_addr = '0;
    logic [LANES-1:0]  s_be = '0;
    logic [7:0]        s_sdata = '0;
    logic [7:0]        sts;
    logic              adone, sdone, sok;
    logic [LANES-1:0]  aperm;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_wel = 0, m_pe = 0, m_blk = 0;
    int e_adone = 0, e_aperm = 0, e_sdone = 0, e_sok = 0;

    always #10 clk = ~clk;

    eeprom_wprot_unit dut (
        .clk (clk), .rst_n (rst_n),
        .wel_set_i (s_set), .wel_clr_i (s_clr),
        .busy_i (s_busy), .wp_pin_i (s_wp),
        .arr_req_i (s_areq), .arr_addr_i (s_addr), .arr_be_i (s_be),
        .sts_req_i (s_sreq), .sts_wdata_i (s_sdata),
        .sts_o (sts), .arr_done_o (adone), .arr_permit_o (aperm),
        .sts_done_o (sdone), .sts_ok_o (sok)
    );

    function automatic bit locked(int blk, int a);
        case (blk)
            0: return 0;
            1: return a >= 24576;
            2: return a >= 16384;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        int exp_sts;
        exp_sts = (m_pe << 7) | (m_blk << 2) | (m_wel << 1) | int'(s_busy);
        chk(tag, "sts", int'(sts), exp_sts);
        chk(tag, "arr_done", int'(adone), e_adone);
        chk(tag, "arr_permit", int'(aperm), e_aperm);
        chk(tag, "sts_done", int'(sdone), e_sdone);
        chk(tag, "sts_ok", int'(sok), e_sok);
    endtask

    // One clock: predict, advance, compare, drop pulses.
    task automatic step(string tag);
        int acc, grant, perm, nwel, la;
        acc   = (s_areq && m_wel == 1 && !s_busy) ? 1 : 0;
        grant = (s_sreq && m_wel == 1 && !s_busy && (m_pe == 0 || s_wp)) ? 1 : 0;
        perm  = 0;
        for (int i = 0; i < LANES; i++) begin
            la = (int'(s_addr) & ~63) + ((int'(s_addr) + i) & 63);
            if (acc == 1 && s_be[i] && !locked(m_blk, la)) perm |= (1 << i);
        end
        nwel = m_wel;
        if (s_clr || acc == 1 || grant == 1) nwel = 0;
        else if (s_set) nwel = 1;
        @(posedge clk);
        @(negedge clk);
        if (grant == 1) begin
            m_pe  = int'(s_sdata[7]);
            m_blk = int'(s_sdata[3:2]);
        end
        m_wel = nwel;
        e_adone = int'(s_areq);
        e_aperm = perm;
        e_sdone = int'(s_sreq);
        e_sok = grant;
        compare(tag);
        s_set = 0; s_clr = 0; s_areq = 0; s_sreq = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R2");

        s_areq = 1; s_addr = 15'h0100; s_be = 4'hF; step("R4");
        s_wp = 1; s_sreq = 1; s_sdata = 8'h8C; step("R4");
        s_set = 1; step("R3");
        s_set = 1; s_clr = 1; step("R3");
        s_set = 1; step("R3");
        s_wp = 0; s_sreq = 1; s_sdata = 8'h04; step("R7");
        step("R9");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h5FFE; s_be = 4'hF; step("R6");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h7FFE; s_be = 4'hF; step("R5");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h5FC2; s_be = 4'b0101; step("R6");
        s_set = 1; step("R3");
        s_wp = 1; s_sreq = 1; s_sdata = 8'h88; step("R8");
        s_set = 1; step("R3");
        s_wp = 0; s_sreq = 1; s_sdata = 8'h00; step("R8");
        step("R9");
        s_areq = 1; s_addr = 15'h1000; s_be = 4'hF; step("R8");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h4000; s_be = 4'hF; step("R5");
        s_set = 1; step("R3");
        s_wp = 1; s_sreq = 1; s_sdata = 8'h8C; step("R11");
        s_wp = 0; step("R11");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h0000; s_be = 4'hF; step("R5");
        s_set = 1; step("R3");
        s_busy = 1; s_wp = 1; s_sreq = 1; s_sdata = 8'h00; step("R10");
        s_areq = 1; s_addr = 15'h0010; s_be = 4'hF; step("R10");
        step("R1");
        s_busy = 0; step("R10");
        s_sreq = 1; s_sdata = 8'h73; step("R1");
        s_set = 1; step("R3");
        s_areq = 1; s_addr = 15'h7FFF; s_be = 4'hF; step("R5");
        s_set = 1; step("R3");
        s_wp = 0; s_sreq = 1; s_sdata = 8'h0C; step("R7");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule